// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block gives every CPU in a cluster two inter-processor interrupt sources, named "other" and "self". Each source has a pending bit and a mask bit per CPU. A CPU raises an "other" interrupt on any set of CPUs by writing a one-hot CPU bitmap to a send register. It clears its own pending and mask bits through write-one-to-act registers. Each CPU has a level interrupt output. The output is high while that CPU has at least one source that is pending and not masked.

A single request port carries the requesting CPU's index with each access. Registers in the low "own view" act on that requesting CPU. Explicit per-CPU views sit above them at a fixed 128-byte stride and act on a named CPU, whoever the caller is. When a CPU reads its event register, it receives a code for the highest-priority deliverable interrupt. That read also masks the delivered source, so software has to clear the mask again once it has handled the interrupt. Read data is registered and appears in the cycle after the read.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every source of every CPU is pending=0 and masked=1, every `irq_o` bit is low, and `rsp_rdata` is zero.
- R2: A write to own-view offset 0x008 sets the "other" pending bit of each CPU c < NCPU whose bit c is set in the written data. Data bits at or above NCPU have no effect.
- R3: A write to own-view offset 0x00C clears the caller's pending bits: data bit 0 clears "other" and bit 31 clears "self". All other data bits, and all other CPUs, are unaffected.
- R4: Own-view writes to offset 0x024 (set) and offset 0x028 (clear) change the caller's mask bits, using bit 0 for "other" and bit 31 for "self". Zero bits and all other data bits leave the mask unchanged.
- R5: A read of own-view offset 0x004 returns 0x0004_0001 if the caller's "other" source is pending and unmasked. Otherwise it returns 0x0004_0002 if "self" is pending and unmasked. Otherwise it returns 0. "Other" always wins over "self".
- R6: An event read that returns a nonzero code sets the mask bit of the delivered source and leaves its pending bit set.
- R7: Per-CPU views start at byte address 0x800 + (cpu << 7). Offsets +0x08, +0x0C, +0x24 and +0x28 set pending, clear pending, set mask and clear mask on that CPU, using bits 0 and 31, whichever CPU makes the request. A view index of NCPU or above changes no state.
- R8: `irq_o[c]` is high exactly when CPU c has a pending, unmasked source, and it reflects a write from the next cycle onward.
- R9: Own-view reads of offset 0x00C return the caller's pending bits and reads of offset 0x024 return its mask bits, each at positions 0 ("other") and 31 ("self"). A read of any other own-view offset returns 0.
- R10: `rsp_rdata` changes only in the cycle after a read and holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NCPU | Per-CPU interrupt level |

## Verification
The bench builds the unit with NCPU=4, which leaves both the default ADDR_W and the 128-byte view stride unchanged. With four CPUs, a send bitmap can carry bits 4 and 5, which must be ignored. A per-CPU view can also name CPU 5, which must leave all state unchanged. Both out-of-range cases can be reached with real addresses. A reference model of pending and mask bits runs alongside the design. It is checked after every operation through the own-view readback of each CPU and through the `irq_o` levels, including the other-before-self ordering on repeated event reads.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  // Source indices inside the 2-bit per-CPU state vectors.
  localparam int SRC_OTHER = 0;
  localparam int SRC_SELF  = 1;

  // Register offsets inside one view (own or per-CPU).
  localparam logic [6:0] OFF_EVENT = 7'h04;
  localparam logic [6:0] OFF_SET   = 7'h08;  // own view: send bitmap
  localparam logic [6:0] OFF_CLR   = 7'h0C;  // own view: acknowledge
  localparam logic [6:0] OFF_MSET  = 7'h24;
  localparam logic [6:0] OFF_MCLR  = 7'h28;

  localparam logic [15:0] EVT_KIND_IPI  = 16'd4;
  localparam logic [15:0] EVT_NUM_OTHER = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF  = 16'd2;

  typedef struct packed {
    logic [1:0] pend_set;
    logic [1:0] pend_clr;
    logic [1:0] mask_set;
    logic [1:0] mask_clr;
  } ipi_ctl_t;

  // Register word layout: "other" at bit 0, "self" at bit 31.
  function automatic logic [1:0] word_to_src(input logic [31:0] w);
    return {w[31], w[0]};
  endfunction

  function automatic logic [31:0] src_to_word(input logic [1:0] s);
    return {s[SRC_SELF], 30'b0, s[SRC_OTHER]};
  endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU       = 8,
  parameter int ADDR_W     = 12,
  parameter int VIEW_SHIFT = 7,
  localparam int CPU_W     = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDX_W     = ADDR_W - 1 - VIEW_SHIFT
) (
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [CPU_W-1:0]        req_cpu,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  input  logic [1:0]              evt_grant_i,
  output ipi_ctl_t [NCPU-1:0]     ctl_o,
  output logic                    rd_any_o,
  output logic                    rd_evt_o,
  output logic                    rd_pend_o,
  output logic                    rd_mask_o
);

  logic                  wr_en;
  logic                  own_view;
  logic                  cpu_view;
  logic [IDX_W-1:0]      view_idx;
  logic [VIEW_SHIFT-1:0] off;
  logic [1:0]            wbits;

  always_comb begin
    wr_en    = req_valid & req_write;
    rd_any_o = req_valid & ~req_write;
    own_view = (req_addr[ADDR_W-1:VIEW_SHIFT] == '0);
    cpu_view = req_addr[ADDR_W-1];
    view_idx = req_addr[ADDR_W-2:VIEW_SHIFT];
    off      = req_addr[VIEW_SHIFT-1:0];
    wbits    = word_to_src(req_wdata);
    rd_evt_o  = rd_any_o & own_view & (off == VIEW_SHIFT'(OFF_EVENT));
    rd_pend_o = rd_any_o & own_view & (off == VIEW_SHIFT'(OFF_CLR));
    rd_mask_o = rd_any_o & own_view & (off == VIEW_SHIFT'(OFF_MSET));
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic [CPU_W-1:0] ME_ID  = CPU_W'(c);
    localparam logic [IDX_W-1:0] TGT_ID = IDX_W'(c);

    ipi_ctl_t ctl;
    logic     is_me;
    logic     is_tgt;
    logic     local_wr;

    always_comb begin
      is_me    = (req_cpu == ME_ID);
      is_tgt   = cpu_view & (view_idx == TGT_ID);
      local_wr = wr_en & ((own_view & is_me) | is_tgt);

      ctl = '0;
      // Send bitmap only raises "other"; explicit view may raise both.
      if (wr_en && own_view && off == VIEW_SHIFT'(OFF_SET) && req_wdata[c])
        ctl.pend_set[SRC_OTHER] = 1'b1;
      if (wr_en && is_tgt && off == VIEW_SHIFT'(OFF_SET))
        ctl.pend_set = ctl.pend_set | wbits;
      if (local_wr && off == VIEW_SHIFT'(OFF_CLR))
        ctl.pend_clr = wbits;
      if (local_wr && off == VIEW_SHIFT'(OFF_MSET))
        ctl.mask_set = wbits;
      if (local_wr && off == VIEW_SHIFT'(OFF_MCLR))
        ctl.mask_clr = wbits;
      // Delivery through the event read masks the granted source.
      if (rd_evt_o && is_me)
        ctl.mask_set = ctl.mask_set | evt_grant_i;
    end

    assign ctl_o[c] = ctl;
  end

endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
  import ipi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ipi_ctl_t   ctl_i,
  output logic [1:0] pend_o,
  output logic [1:0] mask_o,
  output logic       irq_o
);

  logic [1:0] pend_q, pend_d;
  logic [1:0] mask_q, mask_d;
  logic       upd_en;

  always_comb begin
    upd_en = |{ctl_i.pend_set, ctl_i.pend_clr, ctl_i.mask_set, ctl_i.mask_clr};
    pend_d = (pend_q | ctl_i.pend_set) & ~ctl_i.pend_clr;
    mask_d = (mask_q | ctl_i.mask_set) & ~ctl_i.mask_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else if (upd_en) begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);

endmodule

// File: rtl/ipi_event_sel.sv
module ipi_event_sel
  import ipi_pkg::*;
(
  input  logic [1:0]  active_i,
  output logic [1:0]  grant_o,
  output logic [31:0] code_o
);

  always_comb begin
    grant_o = '0;
    code_o  = '0;
    if (active_i[SRC_OTHER]) begin
      grant_o[SRC_OTHER] = 1'b1;
      code_o             = {EVT_KIND_IPI, EVT_NUM_OTHER};
    end else if (active_i[SRC_SELF]) begin
      grant_o[SRC_SELF] = 1'b1;
      code_o            = {EVT_KIND_IPI, EVT_NUM_SELF};
    end
  end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NCPU       = 8,
  parameter int ADDR_W     = 12,
  parameter int VIEW_SHIFT = 7,
  localparam int CPU_W     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic [NCPU-1:0]   irq_o
);

  // Reset asserts asynchronously, releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ipi_ctl_t [NCPU-1:0]   ctl;
  logic [NCPU-1:0][1:0]  pend_w;
  logic [NCPU-1:0][1:0]  mask_w;
  logic [1:0]            caller_pend;
  logic [1:0]            caller_mask;
  logic [1:0]            evt_grant;
  logic [31:0]           evt_code;
  logic                  rd_any, rd_evt, rd_pend, rd_mask;
  logic [31:0]           rdata_q, rdata_d;

  ipi_decode #(
    .NCPU       (NCPU),
    .ADDR_W     (ADDR_W),
    .VIEW_SHIFT (VIEW_SHIFT)
  ) u_decode (
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_cpu     (req_cpu),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .evt_grant_i (evt_grant),
    .ctl_o       (ctl),
    .rd_any_o    (rd_any),
    .rd_evt_o    (rd_evt),
    .rd_pend_o   (rd_pend),
    .rd_mask_o   (rd_mask)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_slice
    ipi_cpu_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .ctl_i  (ctl[c]),
      .pend_o (pend_w[c]),
      .mask_o (mask_w[c]),
      .irq_o  (irq_o[c])
    );
  end

  // State of the requesting CPU.
  always_comb begin
    caller_pend = '0;
    caller_mask = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (req_cpu == CPU_W'(c)) begin
        caller_pend = pend_w[c];
        caller_mask = mask_w[c];
      end
    end
  end

  ipi_event_sel u_evt (
    .active_i (caller_pend & ~caller_mask),
    .grant_o  (evt_grant),
    .code_o   (evt_code)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_evt)       rdata_d = evt_code;
    else if (rd_pend) rdata_d = src_to_word(caller_pend);
    else if (rd_mask) rdata_d = src_to_word(caller_mask);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_any) rdata_q <= rdata_d;
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NCPU       = 8,
  parameter int ADDR_W     = 12,
  parameter int CPU_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [CPU_W-1:0]  req_cpu,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_rdata,
  input logic [NCPU-1:0]   irq_o
);

  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(12'h024);

  // R5: an event read yields only the idle code or one of the two IPI codes.
  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == A_EVT) |=>
      (rsp_rdata == 32'h0 || rsp_rdata == 32'h0004_0001 || rsp_rdata == 32'h0004_0002));

  // R10: read data holds unless a read was accepted.
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    localparam logic [CPU_W-1:0] ID = CPU_W'(c);

    // R3: acknowledging both sources silences the caller's interrupt.
    p_ack_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_cpu == ID && req_addr == A_ACK &&
       req_wdata[0] && req_wdata[31]) |=> !irq_o[c]);

    // R4: masking both sources silences the caller's interrupt.
    p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_cpu == ID && req_addr == A_MSET &&
       req_wdata[0] && req_wdata[31]) |=> !irq_o[c]);

    // R8: an interrupt can only rise after a write.
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[c]) |-> $past(req_valid && req_write));

    // R5: reading the event while the interrupt is up returns an IPI code.
    p_evt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_cpu == ID && req_addr == A_EVT && irq_o[c]) |=>
        (rsp_rdata[31:16] == 16'd4));
  end

endmodule

bind ipi_unit ipi_unit_chk #(
  .NCPU   (NCPU),
  .ADDR_W (ADDR_W),
  .CPU_W  (CPU_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_cpu   (req_cpu),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o)
);

// File: tb/ipi_unit_bench.sv
module ipi_unit_bench;

  localparam int NCPU  = 4;
  localparam int CPU_W = 2;

  localparam logic [11:0] A_EVT  = 12'h004;
  localparam logic [11:0] A_SEND = 12'h008;
  localparam logic [11:0] A_ACK  = 12'h00C;
  localparam logic [11:0] A_MSET = 12'h024;
  localparam logic [11:0] A_MCLR = 12'h028;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [CPU_W-1:0]  req_cpu;
  logic [11:0]       req_addr;
  logic [31:0]       req_wdata;
  logic [31:0]       rsp_rdata;
  logic [NCPU-1:0]   irq_o;

  always #2 clk = ~clk;  // 250 MHz

  ipi_unit #(.NCPU(NCPU)) u_ipi_unit (
    .clk, .rst_n, .req_valid, .req_write, .req_cpu,
    .req_addr, .req_wdata, .rsp_rdata, .irq_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model: bit 0 = other, bit 1 = self.
  logic [1:0] m_pend [NCPU];
  logic [1:0] m_mask [NCPU];

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_rd;

  function automatic logic [31:0] w2(input logic [1:0] s);
    return {s[1], 30'b0, s[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input int cpu, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_cpu   = cpu[CPU_W-1:0];
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic wr_own(input int cpu, input logic [11:0] a, input logic [31:0] d);
    logic [1:0] b;
    b = {d[31], d[0]};
    case (a)
      A_SEND: for (int c = 0; c < NCPU; c++) if (d[c]) m_pend[c][0] = 1'b1;
      A_ACK:  m_pend[cpu] = m_pend[cpu] & ~b;
      A_MSET: m_mask[cpu] = m_mask[cpu] | b;
      A_MCLR: m_mask[cpu] = m_mask[cpu] & ~b;
      default: ;
    endcase
    drive(1'b1, cpu, a, d);
  endtask

  task automatic wr_view(input int cpu, input int tgt, input logic [11:0] off, input logic [31:0] d);
    logic [1:0] b;
    b = {d[31], d[0]};
    if (tgt < NCPU) begin
      case (off)
        A_SEND: m_pend[tgt] = m_pend[tgt] | b;
        A_ACK:  m_pend[tgt] = m_pend[tgt] & ~b;
        A_MSET: m_mask[tgt] = m_mask[tgt] | b;
        A_MCLR: m_mask[tgt] = m_mask[tgt] & ~b;
        default: ;
      endcase
    end
    drive(1'b1, cpu, 12'h800 | 12'(tgt << 7) | off, d);
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, input string tag);
    logic [31:0] e;
    logic [1:0]  act;
    e = '0;
    if (a == A_EVT) begin
      act = m_pend[cpu] & ~m_mask[cpu];
      if (act[0])      begin e = 32'h0004_0001; m_mask[cpu][0] = 1'b1; end
      else if (act[1]) begin e = 32'h0004_0002; m_mask[cpu][1] = 1'b1; end
    end else if (a == A_ACK)  e = w2(m_pend[cpu]);
    else if (a == A_MSET) e = w2(m_mask[cpu]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_rd = e;
    drive(1'b0, cpu, a, 32'h0);
  endtask

  task automatic chk_irq(input string tag);
    for (int c = 0; c < NCPU; c++)
      check({tag, " (R8 irq)"}, 32'(irq_o[c]), 32'(|(m_pend[c] & ~m_mask[c])));
  endtask

  task automatic check_all(input string tag);
    chk_irq(tag);
    for (int c = 0; c < NCPU; c++) begin
      rd(c, A_ACK,  {tag, " (R9 pending)"});
      rd(c, A_MSET, {tag, " (R9 mask)"});
    end
  endtask

  // Scoreboard monitor: pops one expectation per accepted read.
  always @(posedge clk) begin
    if (req_valid && !req_write) begin
      #2;
      if (exp_q.size() == 0) begin
        check("monitor queue empty", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) begin m_pend[c] = 2'b00; m_mask[c] = 2'b11; end
    req_valid = 0; req_write = 0; req_cpu = '0; req_addr = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state at the ports
    check("R1 rdata", rsp_rdata, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    check_all("R1");
    rd(0, A_EVT, "R5 nothing deliverable");

    // R4: unmask caller 0 through the own view
    wr_own(0, A_MCLR, 32'h8000_0001);
    check_all("R4 clear");

    // R2: bitmap with bits beyond NCPU
    wr_own(2, A_SEND, 32'h0000_0031);
    check_all("R2 send");

    // R5 / R6: deliver other, auto-mask, pending stays
    rd(0, A_EVT, "R5 other code");
    check_all("R6 auto-mask");

    // R7: self raised on cpu 0 by cpu 3 through explicit view
    wr_view(3, 0, A_SEND, 32'h8000_0000);
    check_all("R7 set view");
    rd(0, A_EVT, "R5 self code");
    check_all("R6 auto-mask self");

    // R5: priority on cpu 1 with both pending
    wr_view(0, 1, A_MCLR, 32'h8000_0001);
    wr_view(0, 1, A_SEND, 32'h8000_0001);
    check_all("R7 view mask/set");
    rd(1, A_EVT, "R5 other first");
    rd(1, A_EVT, "R5 self second");
    rd(1, A_EVT, "R5 then idle");
    wr_own(1, A_MCLR, 32'h8000_0001);
    check_all("R8 both live");

    // R3: acknowledge only other
    wr_own(1, A_ACK, 32'h0000_0001);
    check_all("R3 ack other");
    wr_own(1, A_MSET, 32'h7FFF_FFFE);
    check_all("R4 zero bits ignored");
    wr_own(1, A_ACK, 32'h7FFF_FFFE);
    check_all("R3 zero bits ignored");
    wr_view(2, 1, A_ACK, 32'h8000_0000);
    check_all("R7 clear view");

    // R7: view index beyond NCPU
    wr_view(0, 5, A_SEND, 32'h8000_0001);
    wr_view(0, 5, A_MCLR, 32'h8000_0001);
    check_all("R7 out-of-range view");

    // R2: multi-target send
    wr_view(1, 3, A_MCLR, 32'h0000_0001);
    wr_own(1, A_SEND, 32'h0000_000C);
    check_all("R2 multi send");

    // R9: unmapped own-view offset reads zero
    rd(3, 12'h010, "R9 unmapped");
    rd(3, A_ACK, "R9 pending cpu3");
    repeat (2) @(posedge clk);
    #1;
    // R10: rdata holds across writes and idle
    wr_own(3, A_MSET, 32'h0000_0001);
    wr_own(2, A_ACK, 32'h0000_0001);
    @(posedge clk);
    #1;
    check("R10 rdata hold", rsp_rdata, last_rd);
    chk_irq("R10 final");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule